// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This unit sits between a local 64-bit bus and a PCIe transaction builder. It maps a local address onto a PCIe-side address through a small bank of programmable outbound windows. Each window holds an enable flag, a two-bit transaction kind, a size mask, a 64-bit local base and a 64-bit target base. The size mask is the complement of (size - 1), so a window is always a power-of-two region aligned to its size. The smallest window is 1 KB.

A 32-bit register port programs the windows and reads them back. A lookup port takes one local address per cycle. One cycle later it reports whether a window claimed the address, which window won, the transaction kind and the translated address. In a typical setup, one window carries configuration accesses, one carries I/O, one carries 32-bit memory and several 4 GB windows cover 64-bit memory. Any window that is not in use stays disabled.

Top module: `oatu_outbound_xlate`

## Requirements
- R1: After reset every window register reads zero, every window is disabled, and every lookup misses.
- R2: The register word address is {window index, 3-bit selector}. The selectors are:
  - 0: control word. Bit 0 is the enable, bits [2:1] are the kind, and bits [31:10] hold mask bits [31:10].
  - 1 and 2: local base, low word then high word.
  - 3 and 4: target base, low word then high word.
  - 5: mask bits [63:32].
  
  Control bits [9:3] read as zero. Selectors 6 and 7 read zero and ignore writes.
- R3: An enabled window hits when (addr & mask) == (local_base & mask). Here mask = {selector 5, control[31:10], 10'b0}.
- R4: On a hit the translated address is (target_base & mask) | (addr & ~mask). The lowest 10 address bits always pass through unchanged.
- R5: When several windows hit, the lowest-numbered window wins.
- R6: On a miss the hit flag, window index, kind and address outputs are all zero.
- R7: A lookup presented in one cycle has its result valid in the next cycle. The valid output is low after any cycle with no lookup, and the result fields keep their last values.
- R8: A register write and a lookup in the same cycle: the lookup sees the window state from before the write.
- R9: A disabled window never hits, even when its base and mask match the address.
- R10: On a hit the kind output equals the winning window's programmed kind: 0 configuration, 1 I/O, 2 memory.
- R11: The mask covers all 64 address bits. A 4 GB window hits over its whole range and misses one byte beyond it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe; data valid next cycle |
| reg_addr | input | IDX_W+3 | Word address {window, selector} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Local address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window claimed the address |
| res_idx | output | IDX_W | Winning window index |
| res_type | output | 2 | Transaction kind of the winner |
| res_addr | output | 64 | Translated address |

## Verification
Two things can land on the same clock edge: a control-word write that enables a window, and a lookup whose address lies inside that window. The bench stages the bases and the upper mask first. It then asserts the control write and the lookup in the same cycle and repeats the lookup in the following cycle. The first result must be a miss that carries all-zero fields. The second must hit that window and return the translated address.

// File: rtl/oatu_pkg.sv
package oatu_pkg;
  localparam int WORD_W        = 32;
  localparam int XADDR_W       = 64;
  localparam int SEL_W         = 3;
  localparam int GRANULE_LSB   = 10;
  localparam int CTRL_MASK_W   = WORD_W - GRANULE_LSB;

  typedef enum logic [1:0] {
    XT_CFG = 2'd0,
    XT_IO  = 2'd1,
    XT_MEM = 2'd2,
    XT_RSV = 2'd3
  } xact_t;

  typedef enum logic [SEL_W-1:0] {
    RS_CTRL  = 3'd0,
    RS_LB_LO = 3'd1,
    RS_LB_HI = 3'd2,
    RS_TB_LO = 3'd3,
    RS_TB_HI = 3'd4,
    RS_SZ_HI = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/oatu_win_regs.sv
module oatu_win_regs
  import oatu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     sel,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  output logic                 en,
  output logic [1:0]           kind,
  output logic [XADDR_W-1:0]   lbase,
  output logic [XADDR_W-1:0]   tbase,
  output logic [XADDR_W-1:0]   mask
);
  logic                   en_q,   en_d;
  logic [1:0]             kind_q, kind_d;
  logic [CTRL_MASK_W-1:0] mlo_q,  mlo_d;
  logic [WORD_W-1:0]      mhi_q,  mhi_d;
  logic [WORD_W-1:0]      lbl_q,  lbl_d;
  logic [WORD_W-1:0]      lbh_q,  lbh_d;
  logic [WORD_W-1:0]      tbl_q,  tbl_d;
  logic [WORD_W-1:0]      tbh_q,  tbh_d;

  always_comb begin
    en_d   = en_q;
    kind_d = kind_q;
    mlo_d  = mlo_q;
    mhi_d  = mhi_q;
    lbl_d  = lbl_q;
    lbh_d  = lbh_q;
    tbl_d  = tbl_q;
    tbh_d  = tbh_q;
    if (wr_en) begin
      case (sel)
        RS_CTRL: begin
          en_d   = wdata[0];
          kind_d = wdata[2:1];
          mlo_d  = wdata[WORD_W-1:GRANULE_LSB];
        end
        RS_LB_LO: lbl_d = wdata;
        RS_LB_HI: lbh_d = wdata;
        RS_TB_LO: tbl_d = wdata;
        RS_TB_HI: tbh_d = wdata;
        RS_SZ_HI: mhi_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      kind_q <= 2'b00;
      mlo_q  <= '0;
      mhi_q  <= '0;
      lbl_q  <= '0;
      lbh_q  <= '0;
      tbl_q  <= '0;
      tbh_q  <= '0;
    end else begin
      en_q   <= en_d;
      kind_q <= kind_d;
      mlo_q  <= mlo_d;
      mhi_q  <= mhi_d;
      lbl_q  <= lbl_d;
      lbh_q  <= lbh_d;
      tbl_q  <= tbl_d;
      tbh_q  <= tbh_d;
    end
  end

  always_comb begin
    case (sel)
      RS_CTRL:  rdata = {mlo_q, {(GRANULE_LSB-3){1'b0}}, kind_q, en_q};
      RS_LB_LO: rdata = lbl_q;
      RS_LB_HI: rdata = lbh_q;
      RS_TB_LO: rdata = tbl_q;
      RS_TB_HI: rdata = tbh_q;
      RS_SZ_HI: rdata = mhi_q;
      default:  rdata = '0;
    endcase
  end

  assign en    = en_q;
  assign kind  = kind_q;
  assign lbase = {lbh_q, lbl_q};
  assign tbase = {tbh_q, tbl_q};
  assign mask  = {mhi_q, mlo_q, {GRANULE_LSB{1'b0}}};
endmodule

// File: rtl/oatu_win_match.sv
module oatu_win_match
  import oatu_pkg::*;
(
  input  logic               en,
  input  logic [XADDR_W-1:0] lbase,
  input  logic [XADDR_W-1:0] tbase,
  input  logic [XADDR_W-1:0] mask,
  input  logic [XADDR_W-1:0] addr,
  output logic               hit,
  output logic [XADDR_W-1:0] xaddr
);
  logic [XADDR_W-1:0] diff;

  always_comb begin
    diff  = (addr ^ lbase) & mask;
    hit   = en && (diff == '0);
    xaddr = (tbase & mask) | (addr & ~mask);
  end
endmodule

// File: rtl/oatu_prio_sel.sv
module oatu_prio_sel
  import oatu_pkg::*;
#(
  parameter  int NUM_WIN = 8,
  localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
)(
  input  logic [NUM_WIN-1:0]              hit_vec,
  input  logic [NUM_WIN-1:0][1:0]         kind_vec,
  input  logic [NUM_WIN-1:0][XADDR_W-1:0] xaddr_vec,
  output logic                            any_hit,
  output logic [IDX_W-1:0]                win_idx,
  output logic [1:0]                      win_kind,
  output logic [XADDR_W-1:0]              win_xaddr
);
  always_comb begin
    any_hit   = 1'b0;
    win_idx   = '0;
    win_kind  = XT_CFG;
    win_xaddr = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit   = 1'b1;
        win_idx   = IDX_W'(i);
        win_kind  = kind_vec[i];
        win_xaddr = xaddr_vec[i];
      end
    end
  end
endmodule

// File: rtl/oatu_outbound_xlate.sv
module oatu_outbound_xlate
  import oatu_pkg::*;
#(
  parameter  int NUM_WIN = 8,
  localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int RA_W    = IDX_W + SEL_W
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  input  logic               lk_valid,
  input  logic [XADDR_W-1:0] lk_addr,
  output logic               res_valid,
  output logic               res_hit,
  output logic [IDX_W-1:0]   res_idx,
  output logic [1:0]         res_type,
  output logic [XADDR_W-1:0] res_addr
);
  // reset synchronizer: asserts at once, releases on the second edge
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic [IDX_W-1:0] win_sel;
  logic [SEL_W-1:0] reg_sel;
  assign win_sel = reg_addr[RA_W-1:SEL_W];
  assign reg_sel = reg_addr[SEL_W-1:0];

  logic [NUM_WIN-1:0]              win_en;
  logic [NUM_WIN-1:0][1:0]         win_kind;
  logic [NUM_WIN-1:0][XADDR_W-1:0] win_lbase;
  logic [NUM_WIN-1:0][XADDR_W-1:0] win_tbase;
  logic [NUM_WIN-1:0][XADDR_W-1:0] win_mask;
  logic [NUM_WIN-1:0][XADDR_W-1:0] win_xaddr;
  logic [NUM_WIN-1:0][WORD_W-1:0]  rd_word;
  logic [NUM_WIN-1:0]              hit_vec;

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    logic wr_here;
    assign wr_here = reg_wr_en && (win_sel == IDX_W'(gi));

    oatu_win_regs u_regs (
      .clk   (clk),
      .rst_n (rst_n_s),
      .wr_en (wr_here),
      .sel   (reg_sel),
      .wdata (reg_wdata),
      .rdata (rd_word[gi]),
      .en    (win_en[gi]),
      .kind  (win_kind[gi]),
      .lbase (win_lbase[gi]),
      .tbase (win_tbase[gi]),
      .mask  (win_mask[gi])
    );

    oatu_win_match u_match (
      .en    (win_en[gi]),
      .lbase (win_lbase[gi]),
      .tbase (win_tbase[gi]),
      .mask  (win_mask[gi]),
      .addr  (lk_addr),
      .hit   (hit_vec[gi]),
      .xaddr (win_xaddr[gi])
    );
  end

  logic                any_hit;
  logic [IDX_W-1:0]    sel_idx;
  logic [1:0]          sel_kind;
  logic [XADDR_W-1:0]  sel_xaddr;

  oatu_prio_sel #(.NUM_WIN(NUM_WIN)) u_prio (
    .hit_vec   (hit_vec),
    .kind_vec  (win_kind),
    .xaddr_vec (win_xaddr),
    .any_hit   (any_hit),
    .win_idx   (sel_idx),
    .win_kind  (sel_kind),
    .win_xaddr (sel_xaddr)
  );

  // register read path
  logic [WORD_W-1:0] rd_mux, rdata_q, rdata_d;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (win_sel == IDX_W'(i)) rd_mux = rd_word[i];
    end
    rdata_d = reg_rd_en ? rd_mux : rdata_q;
  end

  // lookup result stage
  logic               vld_q, vld_d;
  logic               hit_q, hit_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [1:0]         typ_q, typ_d;
  logic [XADDR_W-1:0] xa_q,  xa_d;

  always_comb begin
    vld_d = lk_valid;
    hit_d = hit_q;
    idx_d = idx_q;
    typ_d = typ_q;
    xa_d  = xa_q;
    if (lk_valid) begin
      hit_d = any_hit;
      idx_d = sel_idx;
      typ_d = sel_kind;
      xa_d  = sel_xaddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rdata_q <= '0;
      vld_q   <= 1'b0;
      hit_q   <= 1'b0;
      idx_q   <= '0;
      typ_q   <= 2'b00;
      xa_q    <= '0;
    end else begin
      rdata_q <= rdata_d;
      vld_q   <= vld_d;
      hit_q   <= hit_d;
      idx_q   <= idx_d;
      typ_q   <= typ_d;
      xa_q    <= xa_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign res_valid = vld_q;
  assign res_hit   = hit_q;
  assign res_idx   = idx_q;
  assign res_type  = typ_q;
  assign res_addr  = xa_q;
endmodule

// File: rtl/oatu_checker.sv
module oatu_checker #(
  parameter  int NUM_WIN = 8,
  localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
)(
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [63:0]        lk_addr,
  input logic               res_valid,
  input logic               res_hit,
  input logic [IDX_W-1:0]   res_idx,
  input logic [1:0]         res_type,
  input logic [63:0]        res_addr,
  input logic [NUM_WIN-1:0] win_en
);
  logic [NUM_WIN-1:0] en_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev <= '0;
    else        en_prev <= win_en;
  end

  // R7: a lookup yields a valid result on the next cycle
  a_r7_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);

  // R7: no lookup, no valid result
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);

  // R6: a miss returns all-zero fields
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_type == 2'b00 && res_idx == '0 && res_addr == 64'd0));

  // R4: bits below the 1 KB granule pass straight through
  a_r4_granule_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (res_addr[9:0] == $past(lk_addr[9:0])));

  // R9: the winning window was enabled when the lookup was taken
  a_r9_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> en_prev[res_idx]);
endmodule

bind oatu_outbound_xlate oatu_checker #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .lk_valid  (lk_valid),
  .lk_addr   (lk_addr),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_idx   (res_idx),
  .res_type  (res_type),
  .res_addr  (res_addr),
  .win_en    (win_en)
);

// File: tb/tb_oatu_outbound_xlate.sv
module tb_oatu_outbound_xlate;
  logic        clk;
  logic        rst_n;
  logic        reg_wr_en, reg_rd_en;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        lk_valid;
  logic [63:0] lk_addr;
  logic        res_valid, res_hit;
  logic [2:0]  res_idx;
  logic [1:0]  res_type;
  logic [63:0] res_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  oatu_outbound_xlate #(.NUM_WIN(8)) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
    .res_type(res_type), .res_addr(res_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] ra(input int w, input int s);
    return {w[2:0], s[2:0]};
  endfunction

  task automatic wr(input int w, input int s, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = ra(w, s); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int w, input int s, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = ra(w, s);
    @(negedge clk);
    reg_rd_en = 1'b0;
    chk(reg_rdata == exp, req, "readback", {32'd0, reg_rdata}, {32'd0, exp});
  endtask

  task automatic look(input logic [63:0] a, input bit eh, input logic [2:0] ei,
                      input logic [1:0] et, input logic [63:0] ex, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(res_valid == 1'b1, "R7", "valid", {63'd0, res_valid}, 64'd1);
    chk(res_hit == eh, req, "hit", {63'd0, res_hit}, {63'd0, eh});
    chk(res_idx == ei, req, "index", {61'd0, res_idx}, {61'd0, ei});
    chk(res_type == et, req, "type", {62'd0, res_type}, {62'd0, et});
    chk(res_addr == ex, req, "address", res_addr, ex);
  endtask

  task automatic prog(input int w, input logic [31:0] ctrl, input logic [63:0] lb,
                      input logic [63:0] tb, input logic [31:0] szhi);
    wr(w, 1, lb[31:0]);  wr(w, 2, lb[63:32]);
    wr(w, 3, tb[31:0]);  wr(w, 4, tb[63:32]);
    wr(w, 5, szhi);
    wr(w, 0, ctrl);
  endtask

  task automatic t_reset;
    rd_chk(0, 0, 32'h0, "R1");
    rd_chk(6, 5, 32'h0, "R1");
    rd_chk(3, 2, 32'h0, "R1");
    look(64'h0, 1'b0, 3'd0, 2'd0, 64'h0, "R1");
  endtask

  task automatic t_program;
    prog(0, 32'hFFF0_0001, 64'h4000_0000, 64'h0, 32'hFFFF_FFFF);
    prog(1, 32'hFFFF_0003, 64'h5000_0000, 64'h1_0000, 32'hFFFF_FFFF);
    // R2: control bits [9:3] are dropped
    prog(2, 32'hF000_03FD, 64'h6000_0000, 64'h4000_0000, 32'hFFFF_FFFF);
    prog(3, 32'h0000_0005, 64'h0000_0088_0000_0000, 64'h0000_0012_0000_0000, 32'hFFFF_FFFF);
    rd_chk(2, 0, 32'hF000_0005, "R2");
    rd_chk(3, 2, 32'h0000_0088, "R2");
    rd_chk(1, 3, 32'h0001_0000, "R2");
    // R2: selector 6 ignores writes and reads zero
    wr(0, 6, 32'hDEAD_BEEF);
    rd_chk(0, 6, 32'h0, "R2");
    rd_chk(0, 0, 32'hFFF0_0001, "R2");
  endtask

  task automatic t_translate;
    look(64'h4001_2345, 1'b1, 3'd0, 2'd0, 64'h0001_2345, "R3 R10");
    look(64'h5000_1234, 1'b1, 3'd1, 2'd1, 64'h0001_1234, "R3 R10");
    look(64'h6ABC_DEF0, 1'b1, 3'd2, 2'd2, 64'h4ABC_DEF0, "R4 R10");
    look(64'h0000_0088_DEAD_BEEC, 1'b1, 3'd3, 2'd2, 64'h0000_0012_DEAD_BEEC, "R4 R11");
    look(64'h0000_0088_FFFF_FFFF, 1'b1, 3'd3, 2'd2, 64'h0000_0012_FFFF_FFFF, "R11");
    look(64'h0000_0089_0000_0000, 1'b0, 3'd0, 2'd0, 64'h0, "R11");
  endtask

  task automatic t_priority;
    // R5: window 4 overlaps windows 0..2 (1 GB at 0x4000_0000)
    prog(4, 32'hC000_0005, 64'h4000_0000, 64'h8000_0000, 32'hFFFF_FFFF);
    look(64'h6ABC_DEF0, 1'b1, 3'd2, 2'd2, 64'h4ABC_DEF0, "R5");
    look(64'h4001_2345, 1'b1, 3'd0, 2'd0, 64'h0001_2345, "R5");
    look(64'h7000_0000, 1'b1, 3'd4, 2'd2, 64'hB000_0000, "R5");
  endtask

  task automatic t_disable_miss;
    wr(0, 0, 32'hFFF0_0000);
    look(64'h4001_2345, 1'b1, 3'd4, 2'd2, 64'h8001_2345, "R9");
    look(64'h0000_1000, 1'b0, 3'd0, 2'd0, 64'h0, "R6");
  endtask

  task automatic t_idle_hold;
    @(negedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R7", "valid idle", {63'd0, res_valid}, 64'd0);
    chk(res_hit == 1'b0 && res_addr == 64'h0, "R7", "held address", res_addr, 64'h0);
    look(64'h7000_0000, 1'b1, 3'd4, 2'd2, 64'hB000_0000, "R7");
    @(negedge clk);
    chk(res_addr == 64'hB000_0000 && res_idx == 3'd4, "R7", "held after idle",
        res_addr, 64'hB000_0000);
  endtask

  task automatic t_same_cycle;
    wr(5, 1, 32'h0);  wr(5, 2, 32'h0000_00A0);
    wr(5, 3, 32'h4000); wr(5, 4, 32'h0);
    wr(5, 5, 32'hFFFF_FFFF);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = ra(5, 0); reg_wdata = 32'hFFFF_FC05;
    lk_valid  = 1'b1; lk_addr = 64'h0000_00A0_0000_0155;
    @(negedge clk);
    reg_wr_en = 1'b0;
    chk(res_valid && !res_hit, "R8", "same-cycle miss", {63'd0, res_hit}, 64'd0);
    chk(res_addr == 64'h0 && res_type == 2'd0, "R8", "same-cycle fields", res_addr, 64'h0);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(res_hit && res_idx == 3'd5, "R8", "next-cycle hit", {61'd0, res_idx}, 64'd5);
    chk(res_addr == 64'h4155, "R8", "next-cycle address", res_addr, 64'h4155);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_rd_en = 1'b0; reg_addr = '0;
    reg_wdata = '0; lk_valid = 1'b0; lk_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0 && res_hit == 1'b0, "R1", "outputs after reset",
        {63'd0, res_hit}, 64'd0);
    t_reset();
    t_program();
    t_translate();
    t_priority();
    t_disable_miss();
    t_idle_hold();
    t_same_cycle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule